// File: doc/BRIEF.md
# I2C Slave Byte Transmitter with Clock Stretching

This block is the transmit half of an I2C target. Address recognition happens elsewhere; once the address has matched, a one-cycle `start_tx` pulse hands the bus to this engine. The engine then holds SCL low until the host writes the first byte. A write loads the byte, frees SCL and shifts the byte out most significant bit first. SDA changes only while SCL is low.

After the eighth bit the engine lets go of SDA so that the controller can answer. It samples that answer on the ninth rising SCL edge and records it in `ack_seen`. On the ninth falling edge it pulls SCL low again and pulses `irq_xfer`. After an acknowledge it waits for the next host write, which is the only way to end that stretch. After a not-acknowledge it stops sending. It keeps SCL low until the host strobes `wait_rel`, then frees both lines and waits for a stop.

The bus inputs are resynchronised to the system clock. Start and stop conditions are watched at all times, independently of where the engine is within a byte. Both line outputs are open-drain enables: 1 pulls the line low, 0 leaves it free.

Top module: `i2c_tx_stretch`

## Requirements
- R1: After reset neither line is pulled low, `ack_seen` is 0 and both interrupt outputs are 0.
- R2: A `start_tx` pulse while idle makes the engine pull SCL low and leave SDA free, and it keeps doing so for as long as no byte is written.
- R3: A host write during a stretch frees SCL and puts bit 7 of the byte on SDA. Each later falling SCL edge presents the next lower bit, so the controller reads the byte most significant bit first. SDA changes only while SCL is low.
- R4: On the rising edge of the ninth SCL clock `ack_seen` takes the value 1 if SDA is low (acknowledge) and 0 if SDA is high (not-acknowledge). It keeps that value until the next ninth clock.
- R5: SDA is left free for the ninth clock. On the ninth falling SCL edge the engine pulls SCL low and pulses `irq_xfer` high for exactly one system clock, once per byte.
- R6: After an acknowledge only a host write ends the stretch. A `wait_rel` strobe in this state leaves SCL held low.
- R7: After a not-acknowledge, host writes are ignored: SCL stays held low and SDA stays free. A `wait_rel` strobe then frees SCL.
- R8: A stop condition (SDA rising while SCL is high), in any state and even partway through a byte, pulses `irq_stop` for one clock and returns the engine to idle with both lines free.
- R9: A start condition (SDA falling while SCL is high) partway through a byte returns the engine to idle with both lines free and clears the bit count. After a new `start_tx` and a write, the next byte goes out whole from bit 7.
- R10: While idle, host writes and `wait_rel` strobes have no effect: neither line is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level as seen on the bus |
| sda_i | input | 1 | SDA level as seen on the bus |
| start_tx | input | 1 | One-cycle pulse: address matched, begin transmitting |
| wr_valid | input | 1 | Host write strobe for `wr_data`; also ends a stretch |
| wr_data | input | DATA_W | Byte to transmit |
| wait_rel | input | 1 | Host strobe that frees the bus after a not-acknowledge |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 leaves it free |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 leaves it free |
| ack_seen | output | 1 | Answer sampled in the ninth clock: 1 for acknowledge |
| irq_xfer | output | 1 | One-cycle end-of-byte interrupt |
| irq_stop | output | 1 | One-cycle stop-detected interrupt |

## Verification
The bench builds the block with its default values, DATA_W = 8 and SYNC_STAGES = 2. It drives it from a wired-AND bus model whose controller waits while SCL is held low. With the controller's low and high phases set to eight system clocks, each edge reaches the engine with three clocks of latency. That leaves time to see every data change fall inside a low phase and to check that a stretch actually holds the clock. Random bytes and random session lengths exercise both the acknowledge and the not-acknowledge paths. All-ones bytes leave SDA free, so the controller can raise a stop or a repeated start partway through a byte.

// File: rtl/i2c_tx_pkg.sv
// Shared types for the I2C slave transmitter.
// Assumes: nothing beyond the 1800-2017 language.
package i2c_tx_pkg;

    // Transmit engine phases
    typedef enum logic [2:0] {
        ST_IDLE,      // not addressed, lines free
        ST_STRETCH,   // SCL held low waiting for a host byte
        ST_SHIFT,     // shifting data bits out
        ST_ACKSLOT,   // SDA free, controller answers
        ST_NAKHOLD,   // not-acknowledged, SCL held until wait_rel
        ST_RELEASED   // lines free, waiting for a stop
    } tx_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Resynchronises one open-drain bus line into the system clock domain.
// Provides the synchronised level and its value one clock earlier, so that
// consumers can derive edges. Assumes STAGES >= 2; reset value is the idle
// bus level (high).
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level,
    output logic level_d
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchroniser and keep one delayed copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain   <= '1;
            level_d <= 1'b1;
        end else begin
            chain   <= {chain[STAGES-2:0], line_i};
            level_d <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];

endmodule

// File: rtl/i2c_bus_cond.sv
// Detects start and stop conditions from synchronised line levels.
// A condition counts only while SCL has been high for two samples, so a
// simultaneous release of both lines is not mistaken for a stop.
module i2c_bus_cond (
    input  logic scl_lvl,
    input  logic scl_lvl_d,
    input  logic sda_lvl,
    input  logic sda_lvl_d,
    output logic start_det,
    output logic stop_det
);

    logic scl_steady_high;

    // Classify SDA edges that occur during a steady high SCL
    always_comb begin
        scl_steady_high = scl_lvl & scl_lvl_d;
        start_det       = scl_steady_high & ~sda_lvl & sda_lvl_d;
        stop_det        = scl_steady_high & sda_lvl & ~sda_lvl_d;
    end

endmodule

// File: rtl/i2c_tx_engine.sv
// Byte-level transmit sequencer of the I2C slave.
// Shifts a host byte out MSB first and frees SDA for the answer bit. It
// samples the answer on the ninth rising edge and stretches SCL on the
// ninth falling edge. A stop or start condition returns it to idle.
// Assumes synchronised line levels with one clock of history.
module i2c_tx_engine
    import i2c_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_tx,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wait_rel,
    input  logic              scl_lvl,
    input  logic              scl_lvl_d,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              scl_low,
    output logic              sda_low,
    output logic              ack_seen,
    output logic              irq_xfer,
    output logic              irq_stop
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    tx_state_e         state;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              scl_rise;
    logic              scl_fall;

    // Edge strobes of the synchronised clock line
    always_comb begin
        scl_rise = scl_lvl & ~scl_lvl_d;
        scl_fall = ~scl_lvl & scl_lvl_d;
    end

    // Transmit sequencer: bus conditions first, then the per-phase work
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            scl_low  <= 1'b0;
            sda_low  <= 1'b0;
            ack_seen <= 1'b0;
            irq_xfer <= 1'b0;
            irq_stop <= 1'b0;
        end else begin
            irq_xfer <= 1'b0;
            irq_stop <= 1'b0;
            if (stop_det || start_det) begin
                state    <= ST_IDLE;
                bitcnt   <= '0;
                scl_low  <= 1'b0;
                sda_low  <= 1'b0;
                irq_stop <= stop_det;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (start_tx) begin
                            state   <= ST_STRETCH;
                            scl_low <= 1'b1;
                        end
                    end
                    ST_STRETCH: begin
                        if (wr_valid) begin
                            shreg   <= wr_data;
                            sda_low <= ~wr_data[DATA_W-1];
                            bitcnt  <= '0;
                            scl_low <= 1'b0;
                            state   <= ST_SHIFT;
                        end
                    end
                    ST_SHIFT: begin
                        if (scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                sda_low <= 1'b0;
                                state   <= ST_ACKSLOT;
                            end else begin
                                bitcnt  <= bitcnt + 1'b1;
                                shreg   <= shreg << 1;
                                sda_low <= ~shreg[DATA_W-2];
                            end
                        end
                    end
                    ST_ACKSLOT: begin
                        if (scl_rise) begin
                            ack_seen <= ~sda_lvl;
                        end
                        if (scl_fall) begin
                            scl_low  <= 1'b1;
                            irq_xfer <= 1'b1;
                            state    <= ack_seen ? ST_STRETCH : ST_NAKHOLD;
                        end
                    end
                    ST_NAKHOLD: begin
                        if (wait_rel) begin
                            scl_low <= 1'b0;
                            sda_low <= 1'b0;
                            state   <= ST_RELEASED;
                        end
                    end
                    default: begin
                        state <= ST_RELEASED;
                    end
                endcase
            end
        end
    end

    // R2: a stretch holds the clock and leaves the data line free
    assert_stretch_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STRETCH) |-> (scl_low && !sda_low));

    // R3: data line only moves while the clock line is low during shifting
    assert_sda_moves_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SHIFT) && ($past(state) == ST_SHIFT) && !$stable(sda_low)) |-> !scl_lvl);

    // R4: the answer bit is only recorded during the answer slot
    assert_ack_in_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack_seen) |-> ($past(state) == ST_ACKSLOT));

    // R5: end-of-byte interrupt is a single clock and comes with a stretch
    assert_xfer_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_xfer |-> (scl_low && !sda_low));
    assert_xfer_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_xfer |=> !irq_xfer);

    // R7: after a not-acknowledge the clock stays held and data stays free
    assert_nak_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NAKHOLD) |-> (scl_low && !sda_low && !ack_seen));

    // R8: a stop interrupt always comes with both lines free
    assert_stop_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stop |-> (!scl_low && !sda_low));

endmodule

// File: rtl/i2c_tx_stretch.sv
// I2C slave transmitter top: two line synchronisers, a start/stop
// detector and the transmit engine. Assumes address matching is done
// upstream and signalled by start_tx; outputs are open-drain enables.
module i2c_tx_stretch #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              start_tx,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wait_rel,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic              ack_seen,
    output logic              irq_xfer,
    output logic              irq_stop
);

    localparam int NLINES = 2;
    localparam int IDX_SCL = 0;
    localparam int IDX_SDA = 1;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] lvl_d;
    logic              start_det;
    logic              stop_det;

    assign raw_lines = {sda_i, scl_i};

    // One synchroniser per bus line
    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (raw_lines[g]),
            .level   (lvl[g]),
            .level_d (lvl_d[g])
        );
    end

    i2c_bus_cond u_cond (
        .scl_lvl   (lvl[IDX_SCL]),
        .scl_lvl_d (lvl_d[IDX_SCL]),
        .sda_lvl   (lvl[IDX_SDA]),
        .sda_lvl_d (lvl_d[IDX_SDA]),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tx_engine #(.DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_tx  (start_tx),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .wait_rel  (wait_rel),
        .scl_lvl   (lvl[IDX_SCL]),
        .scl_lvl_d (lvl_d[IDX_SCL]),
        .sda_lvl   (lvl[IDX_SDA]),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_low   (scl_drive_low),
        .sda_low   (sda_drive_low),
        .ack_seen  (ack_seen),
        .irq_xfer  (irq_xfer),
        .irq_stop  (irq_stop)
    );

endmodule

// File: tb/tb_i2c_tx_stretch.sv
// Bench: wired-AND bus model with a stretch-aware controller, random bytes
// and session lengths from a fixed seed, plus directed mid-byte conditions.
module tb_i2c_tx_stretch;

    localparam int CLK_PERIOD = 10;
    localparam int LOW_CYC    = 8;
    localparam int HALF_CYC   = 4;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_tx = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wait_rel = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       scl_drive_low, sda_drive_low, ack_seen, irq_xfer, irq_stop;
    logic       scl_bus, sda_bus;
    int         n_tests = 0;
    int         n_fail = 0;
    int         xfer_cnt = 0;
    int         stop_cnt = 0;
    bit         done = 1'b0;

    assign scl_bus = !(m_scl_low || scl_drive_low);
    assign sda_bus = !(m_sda_low || sda_drive_low);

    i2c_tx_stretch dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .start_tx(start_tx), .wr_valid(wr_valid), .wr_data(wr_data),
        .wait_rel(wait_rel), .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low), .ack_seen(ack_seen),
        .irq_xfer(irq_xfer), .irq_stop(irq_stop)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count interrupt pulses away from the active edge
    always @(negedge clk) begin
        if (irq_xfer) xfer_cnt++;
        if (irq_stop) stop_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rand_byte();
        return 8'($urandom);
    endfunction

    task automatic host_write(input logic [7:0] d);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic pulse_start_tx();
        @(negedge clk); start_tx = 1'b1;
        @(negedge clk); start_tx = 1'b0;
    endtask

    task automatic pulse_wait_rel();
        @(negedge clk); wait_rel = 1'b1;
        @(negedge clk); wait_rel = 1'b0;
    endtask

    // One controller clock, honouring stretching; returns the sampled SDA
    task automatic m_clock(output logic b);
        repeat (LOW_CYC) @(negedge clk);
        m_scl_low = 1'b0;
        while (!scl_bus) @(negedge clk);
        repeat (HALF_CYC) @(negedge clk);
        b = sda_bus;
        repeat (HALF_CYC) @(negedge clk);
        m_scl_low = 1'b1;
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] d);
        logic b;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            m_clock(b);
            d = {d[6:0], b};
        end
        repeat (2) @(negedge clk);
        m_sda_low = give_ack;
        m_clock(b);
        repeat (2) @(negedge clk);
        m_sda_low = 1'b0;
    endtask

    task automatic m_start();
        m_sda_low = 1'b1;
        repeat (6) @(negedge clk);
        m_scl_low = 1'b1;
        repeat (4) @(negedge clk);
        m_sda_low = 1'b0;
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1;
        repeat (4) @(negedge clk);
        m_scl_low = 1'b0;
        while (!scl_bus) @(negedge clk);
        repeat (6) @(negedge clk);
        m_sda_low = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // Sends one byte and checks the byte, answer, stretch and interrupt
    task automatic xfer_byte(input logic [7:0] d, input bit give_ack, input string req);
        logic [7:0] got;
        int x0;
        host_write(d);
        repeat (2) @(negedge clk);
        chk(sda_drive_low == ~d[7], "R3", "first bit on SDA", sda_drive_low, ~d[7]);
        chk(scl_drive_low == 1'b0, "R3", "SCL freed by write", scl_drive_low, 0);
        x0 = xfer_cnt;
        read_byte(give_ack, got);
        chk(got == d, req, "byte read by controller", got, d);
        chk(ack_seen == give_ack, "R4", "answer recorded", ack_seen, give_ack);
        repeat (4) @(negedge clk);
        chk(scl_drive_low && !sda_drive_low, "R5", "stretch after ninth clock",
            {scl_drive_low, sda_drive_low}, 2'b10);
        chk(xfer_cnt - x0 == 1, "R5", "end-of-byte pulses", xfer_cnt - x0, 1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1..: got hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int nbytes;
        int s0;
        logic b;
        logic [7:0] got;
        logic [7:0] d;
        void'($urandom(32'h1c2d_7731));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(!scl_drive_low && !sda_drive_low, "R1", "lines after reset",
            {scl_drive_low, sda_drive_low}, 0);
        chk(!ack_seen && !irq_xfer && !irq_stop, "R1", "status after reset",
            {ack_seen, irq_xfer, irq_stop}, 0);

        // R10 idle ignores host strobes
        host_write(8'h00);
        pulse_wait_rel();
        repeat (4) @(negedge clk);
        chk(!scl_drive_low && !sda_drive_low, "R10", "idle ignores write and release",
            {scl_drive_low, sda_drive_low}, 0);

        // Random sessions: acknowledged bytes then a final not-acknowledge
        for (int s = 0; s < 3; s++) begin
            m_start();
            pulse_start_tx();
            repeat (4) @(negedge clk);
            chk(scl_drive_low && !sda_drive_low, "R2", "stretch after start_tx",
                {scl_drive_low, sda_drive_low}, 2'b10);
            repeat (30) @(negedge clk);
            chk(scl_drive_low, "R2", "stretch persists without write", scl_drive_low, 1);
            nbytes = 2 + int'($urandom % 4);
            for (int i = 0; i < nbytes; i++) begin
                d = (s == 1 && i == 0) ? 8'h00 : rand_byte();
                xfer_byte(d, (i != nbytes - 1), "R3");
                if (i != nbytes - 1) begin
                    pulse_wait_rel();
                    repeat (6) @(negedge clk);
                    chk(scl_drive_low, "R6", "release strobe ignored after acknowledge",
                        scl_drive_low, 1);
                end
            end
            host_write(8'h00);
            repeat (4) @(negedge clk);
            chk(scl_drive_low && !sda_drive_low, "R7", "write ignored after not-acknowledge",
                {scl_drive_low, sda_drive_low}, 2'b10);
            pulse_wait_rel();
            repeat (2) @(negedge clk);
            chk(!scl_drive_low && !sda_drive_low, "R7", "release frees bus",
                {scl_drive_low, sda_drive_low}, 0);
            s0 = stop_cnt;
            m_stop();
            chk(stop_cnt - s0 == 1, "R8", "stop interrupt pulses", stop_cnt - s0, 1);
            chk(!scl_drive_low && !sda_drive_low, "R8", "idle after stop",
                {scl_drive_low, sda_drive_low}, 0);
        end

        // R9 repeated start partway through a byte
        m_start();
        pulse_start_tx();
        repeat (4) @(negedge clk);
        host_write(8'hFF);
        for (int i = 0; i < 3; i++) m_clock(b);
        repeat (LOW_CYC) @(negedge clk);
        m_scl_low = 1'b0;
        while (!scl_bus) @(negedge clk);
        repeat (4) @(negedge clk);
        m_sda_low = 1'b1;
        repeat (6) @(negedge clk);
        chk(!scl_drive_low && !sda_drive_low, "R9", "idle after repeated start",
            {scl_drive_low, sda_drive_low}, 0);
        m_scl_low = 1'b1;
        repeat (4) @(negedge clk);
        m_sda_low = 1'b0;
        pulse_start_tx();
        repeat (4) @(negedge clk);
        d = rand_byte();
        xfer_byte(d, 1'b0, "R9");
        pulse_wait_rel();
        m_stop();

        // R8 stop partway through a byte
        m_start();
        pulse_start_tx();
        repeat (4) @(negedge clk);
        host_write(8'hFF);
        for (int i = 0; i < 2; i++) m_clock(b);
        s0 = stop_cnt;
        repeat (2) @(negedge clk);
        m_stop();
        chk(stop_cnt - s0 == 1, "R8", "mid-byte stop interrupt", stop_cnt - s0, 1);
        chk(!scl_drive_low && !sda_drive_low, "R8", "idle after mid-byte stop",
            {scl_drive_low, sda_drive_low}, 0);
        got = 8'h00;
        chk(got == 8'h00 && !irq_stop, "R8", "stop pulse is one clock", irq_stop, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule